// File: doc/BRIEF.md
# Fractional-Prescaled Serial Bit-Rate Tick Generator

This block turns a fast module clock into the timing ticks a serial controller needs. A fractional prescaler adds a programmable step to a 10-bit phase accumulator on every clock. It produces an enable pulse whenever the accumulator wraps, so the average enable rate is step/1024 of the clock. A step of zero bypasses the prescaler, and the enable is then present on every clock. The enable pulses decrement a 13-bit reload counter. Each time the counter passes zero it reloads and marks one underflow.

In asynchronous mode, every underflow becomes one oversampling tick. The serial logic, which is not part of this block, uses sixteen of these ticks per bit. In synchronous mode, one shift tick comes out for every eighth underflow. With equal settings, the synchronous bit rate is therefore twice the asynchronous one. Because the prescaler is fractional, the resulting rate can be set finer than integer division of the clock allows. Clearing the run input parks the whole chain in a known phase.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the chain is run, `async_tick` and `sync_tick` are both 0.
- R2: While `run_en` is 0, no tick is produced. The accumulator is held at zero and the counter follows `reload_val`. When `run_en` returns to 1, the next run starts from that fresh phase.
- R3: With a nonzero `frac_step` s, the prescaler enables on the n-th clock edge of a run (n counted from 1) exactly when floor(n*s/1024) differs from floor((n-1)*s/1024).
- R4: With `frac_step` equal to 0, the prescaler is bypassed and enables on every clock edge of a run.
- R5: The first underflow happens on the (reload+1)-th enable of a run. Each later underflow follows the previous one after (reload+1) enables. Reload values span the full 13 bits, 0 to 8191. A tick is visible in the cycle after the clock edge that carried the underflowing enable.
- R6: A new `reload_val` is picked up only at an underflow. A change made mid-count does not alter the period in progress.
- R7: With `mode_sel` 0 (asynchronous), `async_tick` pulses for one cycle at every underflow and `sync_tick` stays 0.
- R8: With `mode_sel` 1 (synchronous), `sync_tick` pulses for one cycle at every eighth underflow of a run, starting with the eighth. `async_tick` stays 0.
- R9: The count of underflows toward the next synchronous tick is cleared while `run_en` is 0 or `mode_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | 1 runs the divider chain; 0 parks it |
| reload_val | input | 13 | Reload value of the down-counter |
| frac_step | input | 10 | Accumulator step of the prescaler; 0 bypasses it |
| mode_sel | input | 1 | 0 asynchronous oversampling ticks, 1 synchronous shift ticks |
| async_tick | output | 1 | One-cycle oversampling tick |
| sync_tick | output | 1 | One-cycle synchronous shift tick |

## Verification
The bench drives step values that divide 1024 evenly and also ones that leave a remainder, such as 300. A prescaler that mishandles the carry would put ticks in the wrong cycles only in the fractional case.

It changes the reload value in the middle of a count. A counter that reloads too eagerly would shorten the running period. It also uses reload 0 with the prescaler bypassed, where a tick is due on every cycle, and the full 13-bit reload of 8191. A design that gets these wrong would lose back-to-back ticks or wrap early.

It drops and restores `run_en` and checks that the next run starts from a clean phase. Any leftover accumulator or synchronous count would show up as a shifted first tick.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic {
    SER_ASYNC = 1'b0,
    SER_SYNC  = 1'b1
  } ser_mode_e;

  localparam int unsigned BT_ACC_W    = 10;
  localparam int unsigned BT_CNT_W    = 13;
  localparam int unsigned BT_SYNC_DIV = 8;

endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/bt_frac_presc.sv
module bt_frac_presc #(
  parameter int unsigned ACC_W       = 10,
  parameter bit          ZERO_BYPASS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] step,
  output logic             en
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   sum;
  logic             carry;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, step};
    carry = sum[ACC_W];
  end

  generate
    if (ZERO_BYPASS) begin : g_bypass
      always_comb begin
        en = run && ((step == '0) || carry);
      end
    end else begin : g_plain
      always_comb begin
        en = run && carry;
      end
    end
  endgenerate

  always_comb begin
    if (!run) begin
      acc_d = '0;
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/bt_reload_cnt.sv
module bt_reload_cnt #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic             uf
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    uf      = run && en && at_zero;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = reload;
    end else if (en) begin
      if (at_zero) begin
        cnt_d = reload;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bt_tick_shape.sv
module bt_tick_shape
  import bt_pkg::*;
#(
  parameter int unsigned SYNC_DIV = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  ser_mode_e mode,
  input  logic      uf,
  output logic      async_tick,
  output logic      sync_tick
);

  localparam int unsigned SW = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;
  localparam logic [SW-1:0] LAST = SW'(SYNC_DIV - 1);

  logic [SW-1:0] scnt_q;
  logic [SW-1:0] scnt_d;
  logic          at_q;
  logic          at_d;
  logic          st_q;
  logic          st_d;
  logic          sync_on;

  always_comb begin
    sync_on = run && (mode == SER_SYNC);
    at_d    = run && (mode == SER_ASYNC) && uf;
    st_d    = sync_on && uf && (scnt_q == LAST);
    scnt_d  = scnt_q;
    if (!sync_on) begin
      scnt_d = '0;
    end else if (uf) begin
      scnt_d = (scnt_q == LAST) ? '0 : scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      at_q   <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      scnt_q <= scnt_d;
      at_q   <= at_d;
      st_q   <= st_d;
    end
  end

  assign async_tick = at_q;
  assign sync_tick  = st_q;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bt_pkg::*;
#(
  parameter int unsigned ACC_W    = BT_ACC_W,
  parameter int unsigned CNT_W    = BT_CNT_W,
  parameter int unsigned SYNC_DIV = BT_SYNC_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [ACC_W-1:0] frac_step,
  input  logic             mode_sel,
  output logic             async_tick,
  output logic             sync_tick
);

  logic      rst_n_i;
  logic      presc_en;
  logic      underflow;
  ser_mode_e mode;

  assign mode = ser_mode_e'(mode_sel);

  bt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  bt_frac_presc #(.ACC_W(ACC_W), .ZERO_BYPASS(1'b1)) u_presc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (run_en),
    .step  (frac_step),
    .en    (presc_en)
  );

  bt_reload_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .run    (run_en),
    .en     (presc_en),
    .reload (reload_val),
    .uf     (underflow)
  );

  bt_tick_shape #(.SYNC_DIV(SYNC_DIV)) u_shape (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .run        (run_en),
    .mode       (mode),
    .uf         (underflow),
    .async_tick (async_tick),
    .sync_tick  (sync_tick)
  );

endmodule

// File: rtl/bt_checker.sv
module bt_checker (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic mode_sel,
  input logic async_tick,
  input logic sync_tick
);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!async_tick && !sync_tick));

  a_r7_no_sync_in_async: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |=> !sync_tick);

  a_r8_no_async_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |=> !async_tick);

  a_r8_sync_not_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    sync_tick |=> !sync_tick);

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({async_tick, sync_tick}));

endmodule

bind baud_tick_gen bt_checker u_bt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .mode_sel   (mode_sel),
  .async_tick (async_tick),
  .sync_tick  (sync_tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic [12:0] reload_val;
  logic [9:0]  frac_step;
  logic        mode_sel;
  logic        async_tick;
  logic        sync_tick;

  baud_tick_gen i_baud_tick_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .reload_val (reload_val),
    .frac_step  (frac_step),
    .mode_sel   (mode_sel),
    .async_tick (async_tick),
    .sync_tick  (sync_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic        ea;
    logic        es;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // reference state, built from the requirements
  int m_n, m_e, m_target, m_suf;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic cycle();
    exp_t x;
    bit en, uf;
    @(posedge clk);
    x.ea = 1'b0; x.es = 1'b0; x.tag = cur_tag;
    if (run_en) begin
      m_n++;
      if (frac_step == 0) en = 1'b1;           // R4
      else en = ((m_n * int'(frac_step)) / 1024) != (((m_n - 1) * int'(frac_step)) / 1024); // R3
      uf = 1'b0;
      if (en) begin
        m_e++;
        if (m_e == m_target) begin             // R5 / R6
          uf = 1'b1;
          m_target = m_e + int'(reload_val) + 1;
        end
      end
      x.ea = uf && !mode_sel;                  // R7
      if (!mode_sel) m_suf = 0;                // R9
      else if (uf) begin
        m_suf++;
        if (m_suf % 8 == 0) x.es = 1'b1;       // R8
      end
    end else begin
      m_n = 0; m_e = 0; m_suf = 0;             // R2
      m_target = int'(reload_val) + 1;
    end
    exp_q.push_back(x);
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) cycle();
  endtask

  task automatic setup(input int rl, input int st, input bit md, input string tag);
    @(negedge clk);
    run_en = 1'b0; reload_val = 13'(rl); frac_step = 10'(st); mode_sel = md; cur_tag = tag;
    cycles(2);
    @(negedge clk);
    run_en = 1'b1;
  endtask

  // monitor: compares outputs against the queue away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        n_chk++;
        if (async_tick !== x.ea || sync_tick !== x.es) begin
          n_fail++;
          $display("FAIL %s: async/sync = %b%b, expected %b%b at %0t",
                   x.tag, async_tick, sync_tick, x.ea, x.es, $time);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; reload_val = '0; frac_step = '0; mode_sel = 1'b0;
    m_n = 0; m_e = 0; m_suf = 0; m_target = 1;
    repeat (3) @(negedge clk);
    n_chk++;                                   // R1 during reset
    if (async_tick !== 1'b0 || sync_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: async/sync = %b%b, expected 00", async_tick, sync_tick);
    end
    rst_n = 1'b1;
    cur_tag = "R1";
    cycles(5);

    setup(0, 0, 1'b0, "R4");    cycles(20);    // tick every cycle
    setup(3, 0, 1'b0, "R5");    cycles(40);
    setup(2, 256, 1'b0, "R3");  cycles(60);    // even fraction
    setup(1, 300, 1'b0, "R3");  cycles(120);   // uneven fraction
    setup(1, 0, 1'b1, "R8");    cycles(70);
    setup(0, 512, 1'b1, "R8");  cycles(80);

    setup(6, 0, 1'b0, "R6");    cycles(10);    // mid-count reload change
    @(negedge clk); reload_val = 13'd2;
    cycles(30);

    setup(4, 700, 1'b1, "R9");  cycles(50);    // idle then fresh restart
    @(negedge clk); run_en = 1'b0; cur_tag = "R2";
    cycles(12);
    @(negedge clk); run_en = 1'b1; cur_tag = "R9";
    cycles(120);

    setup(8191, 0, 1'b0, "R5"); cycles(16400); // full 13-bit reload

    @(negedge clk); run_en = 1'b0; cur_tag = "R2";
    cycles(10);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule